// File: doc/BRIEF.md
# Lane Byte Word Aligner

This block sits behind a 1:8 deserializer on one high-speed camera serial lane. Each cycle of the byte clock (one quarter of the double-data-rate lane clock) it receives an 8-bit word whose byte boundary is unknown. It keeps the previous word next to the current one, forming a 16-bit window, and looks for the high-speed sync leader byte at each of the eight bit offsets. Bits are taken to arrive least significant first, so window bit 0 is bit 0 of the previous word and window bit 15 is bit 7 of the current word.

A two-state machine controls the search. In `ST_HUNT` the block scans the window each cycle and emits nothing valid. When the leader is found, it moves to `ST_LOCK` (transition *lock*), latches the matching offset, and registers the leader byte itself as the first valid output, marked by a one-cycle start flag that later lane-merging stages use. In `ST_LOCK` every input word yields one aligned byte at the held offset. An end-of-burst input returns it to `ST_HUNT` (transition *release*). Low-power lane signalling never reaches the block. Only high-speed words are handled.

Top module: `byte_word_aligner`

## Requirements
- R1: During and right after reset, `aligned_valid` and `sot` are 0 and `aligned_byte` is 0x00.
- R2: In `ST_HUNT`, if the window (previous word in bits 0..7, current word in bits 8..15) holds the leader 0xB8 in bits k..k+7 for any k from 0 to 7, the next cycle shows `aligned_byte` = 0xB8, `aligned_valid` = 1 and `sot` = 1.
- R3: In `ST_LOCK`, each input word yields, one cycle later, `aligned_byte` = window bits k..k+7 at the locked offset k, with `aligned_valid` = 1 and `sot` = 0.
- R4: While locked, the offset does not change and `sot` stays 0, even when the leader appears in the window at another offset.
- R5: `hs_end` high in `ST_LOCK` makes the next output `aligned_valid` = 0, `aligned_byte` = 0x00, and the block hunts again, re-locking at a new offset on the next leader.
- R6: If several offsets match in the same cycle, the lowest offset is locked.
- R7: In `ST_HUNT` with no match, the next output has `aligned_valid` = 0, `sot` = 0 and `aligned_byte` = 0x00.
- R8: `hs_end` high in a `ST_HUNT` cycle whose window matches prevents the lock: the output stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock (lane clock divided by four) |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_word | input | 8 | Unaligned deserialized word, oldest bit in bit 0 |
| hs_end | input | 1 | End of high-speed burst; releases the lock |
| aligned_byte | output | 8 | Byte-aligned word, 0x00 when not valid |
| aligned_valid | output | 1 | High while locked and producing bytes |
| sot | output | 1 | One-cycle flag on the leader byte |

## Verification
A wrong locked offset shows up on the first byte after the leader as a bit-shifted value, one cycle after the word that follows the leader. A state machine stuck in `ST_LOCK` or `ST_HUNT` shows up one cycle after `hs_end` or after the completing leader word, as a valid flag with the wrong level. The sweep places the leader at every offset, puts a misplaced leader inside the locked payload, and uses a second instance with a self-overlapping leader so that the priority among simultaneous matches becomes visible in the byte that follows.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    localparam int unsigned BWA_BYTE_W     = 8;
    localparam logic [7:0]  BWA_LEADER_DEF = 8'hB8;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } bwa_state_e;
endpackage

// File: rtl/bwa_window.sv
// Holds the previous word; window = {current, previous}, oldest bit at 0.
module bwa_window #(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   cur_word,
    output logic [2*W-1:0] win
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_word;
    end

    assign win = {cur_word, prev_q};
endmodule

// File: rtl/bwa_leader_search.sv
// Compares the window against the leader at every offset; lowest hit wins.
module bwa_leader_search #(
    parameter int unsigned W      = 8,
    parameter logic [W-1:0] LEADER = 8'hB8,
    localparam int unsigned OFFW  = $clog2(W)
) (
    input  logic [2*W-1:0]  win,
    output logic            found,
    output logic [OFFW-1:0] hit_off
);
    logic [W-1:0] hits;

    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign hits[k] = (win[k +: W] == LEADER);
    end

    always_comb begin
        found   = |hits;
        hit_off = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hits[k]) hit_off = OFFW'(k);
        end
    end
endmodule

// File: rtl/bwa_byte_pick.sv
// Selects W bits of the window starting at the given offset.
module bwa_byte_pick #(
    parameter int unsigned W     = 8,
    localparam int unsigned OFFW = $clog2(W)
) (
    input  logic [2*W-1:0]  win,
    input  logic [OFFW-1:0] sel,
    output logic [W-1:0]    byte_o
);
    assign byte_o = win[sel +: W];
endmodule

// File: rtl/byte_word_aligner.sv
module byte_word_aligner
    import bwa_pkg::*;
#(
    parameter int unsigned  W      = BWA_BYTE_W,
    parameter logic [W-1:0] LEADER = BWA_LEADER_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lane_word,
    input  logic         hs_end,
    output logic [W-1:0] aligned_byte,
    output logic         aligned_valid,
    output logic         sot
);
    localparam int unsigned OFFW = $clog2(W);

    bwa_state_e      state_q, state_d;
    logic [2*W-1:0]  win;
    logic            found;
    logic [OFFW-1:0] hit_off;
    logic [OFFW-1:0] off_q;
    logic [OFFW-1:0] sel;
    logic [W-1:0]    picked;
    logic            take_lock;

    bwa_window #(.W(W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_word (lane_word),
        .win      (win)
    );

    bwa_leader_search #(.W(W), .LEADER(LEADER)) u_search (
        .win     (win),
        .found   (found),
        .hit_off (hit_off)
    );

    assign sel = (state_q == ST_HUNT) ? hit_off : off_q;

    bwa_byte_pick #(.W(W)) u_pick (
        .win    (win),
        .sel    (sel),
        .byte_o (picked)
    );

    assign take_lock = found && !hs_end;

    // Next-state logic: lock on a leader, release on end of burst.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (take_lock) state_d = ST_LOCK;
            ST_LOCK: if (hs_end)    state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Output and offset registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q         <= '0;
            aligned_byte  <= '0;
            aligned_valid <= 1'b0;
            sot           <= 1'b0;
        end else begin
            aligned_byte  <= '0;
            aligned_valid <= 1'b0;
            sot           <= 1'b0;
            unique case (state_q)
                ST_HUNT: begin
                    if (take_lock) begin
                        off_q         <= hit_off;
                        aligned_byte  <= picked;
                        aligned_valid <= 1'b1;
                        sot           <= 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (!hs_end) begin
                        aligned_byte  <= picked;
                        aligned_valid <= 1'b1;
                    end
                end
            endcase
        end
    end

    // R2: the start flag only ever marks a valid byte
    p_sot_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sot |-> aligned_valid);

    // R4: a locked burst keeps its offset and raises no new start flag
    p_hold_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !hs_end) |=> (!sot && $stable(off_q)));

    // R5: end of burst clears the output in the next cycle
    p_end_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hs_end |=> (!aligned_valid && aligned_byte == '0));

    // R7: an invalid output carries a zero byte and no start flag
    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned_valid |-> (aligned_byte == '0 && !sot));

    // R8: end of burst while hunting blocks a lock
    p_end_blocks_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && hs_end) |=> (state_q == ST_HUNT && !aligned_valid));
endmodule

// File: tb/tb_byte_word_aligner.sv
module tb_byte_word_aligner;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] lane_word;
    logic [7:0] alt_word;
    logic       hs_end;
    logic [7:0] a_byte, b_byte;
    logic       a_vld, b_vld, a_sot, b_sot;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    byte_word_aligner dut (
        .clk(clk), .rst_n(rst_n), .lane_word(lane_word), .hs_end(hs_end),
        .aligned_byte(a_byte), .aligned_valid(a_vld), .sot(a_sot)
    );

    // Second instance with a self-overlapping leader to expose priority.
    byte_word_aligner #(.W(8), .LEADER(8'h55)) dut_alt (
        .clk(clk), .rst_n(rst_n), .lane_word(alt_word), .hs_end(hs_end),
        .aligned_byte(b_byte), .aligned_valid(b_vld), .sot(b_sot)
    );

    task automatic chk(input string tag, input logic [7:0] gb, input logic gv,
                       input logic gs, input logic [7:0] eb, input logic ev,
                       input logic es);
        n_cmp++;
        if (gb !== eb || gv !== ev || gs !== es) begin
            n_bad++;
            $display("FAIL %s: got byte=%h vld=%b sot=%b expected byte=%h vld=%b sot=%b",
                     tag, gb, gv, gs, eb, ev, es);
        end
    endtask

    task automatic step(input logic [7:0] w, input logic e, input logic [7:0] wa);
        @(negedge clk);
        lane_word = w;
        hs_end    = e;
        alt_word  = wa;
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [127:0] s;
        rst_n = 1'b0; lane_word = '0; alt_word = '0; hs_end = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 in reset", a_byte, a_vld, a_sot, 8'h00, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 after reset", a_byte, a_vld, a_sot, 8'h00, 1'b0, 1'b0);
        chk("R1 after reset alt", b_byte, b_vld, b_sot, 8'h00, 1'b0, 1'b0);

        // R8: window {00,B8} matches at offset 0, but hs_end blocks the lock
        step(8'hB8, 1'b0, 8'h00);
        chk("R7 hunt no match", a_byte, a_vld, a_sot, 8'h00, 1'b0, 1'b0);
        step(8'h00, 1'b1, 8'h00);
        chk("R8 lock blocked", a_byte, a_vld, a_sot, 8'h00, 1'b0, 1'b0);
        step(8'h00, 1'b0, 8'h00);
        chk("R8 still hunting", a_byte, a_vld, a_sot, 8'h00, 1'b0, 1'b0);

        // Sweep of every bit offset: zeros, leader at bit 16+k, payload after it.
        for (int k = 0; k < 8; k++) begin
            s = '0;
            s[16+k +: 8] = 8'hB8;
            for (int m = 1; m <= 6; m++)
                s[16+k+8*m +: 8] = 8'(k*53 + m*29 + 7);
            s[16+k+11 +: 8] = 8'hB8;   // misplaced leader inside payload (R4)
            for (int j = 0; j < 3; j++) begin
                step(s[8*j +: 8], 1'b0, 8'h00);
                chk($sformatf("R7 hunt k=%0d j=%0d", k, j), a_byte, a_vld, a_sot,
                    8'h00, 1'b0, 1'b0);
            end
            step(s[24 +: 8], 1'b0, 8'h00);
            chk($sformatf("R2 leader k=%0d", k), a_byte, a_vld, a_sot, 8'hB8, 1'b1, 1'b1);
            for (int m = 1; m <= 6; m++) begin
                step(s[24+8*m +: 8], 1'b0, 8'h00);
                chk($sformatf("R3/R4 payload k=%0d m=%0d", k, m), a_byte, a_vld, a_sot,
                    s[16+k+8*m +: 8], 1'b1, 1'b0);
            end
            step(s[80 +: 8], 1'b1, 8'h00);
            chk($sformatf("R5 release k=%0d", k), a_byte, a_vld, a_sot, 8'h00, 1'b0, 1'b0);
            step(8'h00, 1'b0, 8'h00);
            chk($sformatf("R5 hunting k=%0d", k), a_byte, a_vld, a_sot, 8'h00, 1'b0, 1'b0);
        end

        // R6: window 0x5555 matches offsets 0,2,4,6; offset 0 must be kept.
        step(8'h00, 1'b0, 8'h55);
        chk("R7 alt hunt", b_byte, b_vld, b_sot, 8'h00, 1'b0, 1'b0);
        step(8'h00, 1'b0, 8'h55);
        chk("R6 alt leader", b_byte, b_vld, b_sot, 8'h55, 1'b1, 1'b1);
        step(8'h00, 1'b0, 8'h0F);
        chk("R6 alt offset0 byte1", b_byte, b_vld, b_sot, 8'h55, 1'b1, 1'b0);
        step(8'h00, 1'b0, 8'h33);
        chk("R6 alt offset0 byte2", b_byte, b_vld, b_sot, 8'h0F, 1'b1, 1'b0);
        chk("R7 main idle", a_byte, a_vld, a_sot, 8'h00, 1'b0, 1'b0);
        step(8'h00, 1'b1, 8'h00);
        chk("R5 alt release", b_byte, b_vld, b_sot, 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no end expected end of sequence");
            summary();
            $finish;
        end
    end
endmodule